// File: doc/BRIEF.md
# Vector Length Setting Unit

This execution unit holds the two pieces of architectural state that govern vector loops: the current vector length (VL) and the maximum vector length (MVL). It accepts a 32-bit set-vector-length instruction together with a valid strobe and completes it in a single cycle. The instruction can reload MVL, VL or both from a 6-bit immediate, or clamp VL against a count taken from a general-purpose source register. VL never rises above MVL.

The resulting VL can be copied into a general-purpose destination register in the same cycle, so a loop can subtract the element count it is about to process without a separate read of VL. When the record bit is set, a condition field is also updated from the new VL. A zero VL raises the equal flag, so a following branch can skip or leave the loop. The unit drives the read address of the source register, takes the register value back combinationally and presents the write port in the same cycle. VL, MVL and the condition field are registered.

Top module: `svl_unit`

## Requirements
- R1: An instruction is accepted only when insn[31:26] equals MAJOR_OP and insn[5:1] equals XO_SUB. Any other word presented with insn_valid raises `illegal` in that cycle, performs no register write, and leaves VL, MVL and CR0 unchanged.
- R2: The fields are placed as follows: RT = insn[25:21], immediate = insn[20:15], set-MVL flag = insn[14], set-VL flag = insn[13], RA = insn[10:6], record bit = insn[0]. insn[12:11] are ignored. `rs_addr` always shows the RA field.
- R3: An immediate of 0 is read as 64. Every other immediate value is read as itself.
- R4: When the set-MVL flag is 1, MVL takes the immediate value on the next edge. Otherwise MVL keeps its value.
- R5: The new VL is min(base, new MVL), where base is the immediate value when the set-VL flag is 1 and the old VL otherwise. When the RA field is nonzero, the new VL is additionally limited to rs_data, taken as an unsigned XLEN-bit value. VL takes this value on the next edge.
- R6: When RT is nonzero, an accepted instruction asserts `rd_we` in the same cycle, with `rd_addr` = RT and `rd_data` = the new VL zero-extended. When RT is 0, nothing is written, but VL and MVL are still updated.
- R7: When the RA field is 0, `rs_data` has no effect on any output.
- R8: When the record bit is 1, cr0 = {lt, gt, eq, so} = {0, VL!=0, VL==0, 0} from the new VL on the next edge. When the record bit is 0, CR0 keeps its value.
- R9: After reset, VL, MVL and CR0 are all 0.
- R10: VL never exceeds MVL, and MVL never exceeds 64.
- R11: A source value of 0 with a nonzero RA field gives VL = 0 and writes 0 to RT. With the record bit set, this sets the eq bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| insn_valid | input | 1 | Instruction word is presented this cycle |
| insn | input | 32 | Instruction word |
| rs_addr | output | 5 | Source register address (the RA field) |
| rs_data | input | XLEN | Source register value returned for rs_addr |
| rd_we | output | 1 | Destination register write enable |
| rd_addr | output | 5 | Destination register address |
| rd_data | output | XLEN | Value written to the destination register (the new VL) |
| vl | output | 7 | Current vector length |
| mvl | output | 7 | Current maximum vector length |
| cr0 | output | 4 | Condition field {lt, gt, eq, so} |
| illegal | output | 1 | Presented word is not this instruction |

## Verification
The bench builds the unit with its default parameters: a 64-bit XLEN, MAJOR_OP = 22 and XO_SUB = 27. Because the immediate is only six bits wide, these parameters let the bench walk every immediate value under every combination of the two set flags, the RA selection and the record bit. Each of these 1024 operations is paired with source values that sit below, at and above the current limits, including a large value whose low bits are small, which exposes any truncation of the source before the compare. A full sweep of the 64 major opcodes and the 32 fixed extended-opcode values checks acceptance and rejection exhaustively.

// File: rtl/svl_pkg.sv
package svl_pkg;

  localparam int IMM_W   = 6;
  localparam int VL_W    = IMM_W + 1;
  localparam int RADDR_W = 5;
  localparam int MAXVL   = 1 << IMM_W;

  // 32-bit word, most significant field first (big-endian bit 0 = insn[31])
  typedef struct packed {
    logic [5:0]         major;
    logic [RADDR_W-1:0] rt;
    logic [IMM_W-1:0]   imm;
    logic               set_mvl;
    logic               set_vl;
    logic [1:0]         rsvd;
    logic [RADDR_W-1:0] ra;
    logic [4:0]         xo_fix;
    logic               rc;
  } svl_word_t;

  function automatic logic [VL_W-1:0] umin(input logic [VL_W-1:0] a,
                                           input logic [VL_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/svl_decode.sv
module svl_decode
  import svl_pkg::*;
#(
  parameter logic [5:0] MAJOR_OP = 6'd22,
  parameter logic [4:0] XO_SUB   = 5'd27
) (
  input  logic            insn_valid,
  input  logic [31:0]     insn,
  output svl_word_t       fields,
  output logic [VL_W-1:0] imm_val,
  output logic            accept,
  output logic            illegal
);

  logic match;

  always_comb begin
    fields  = svl_word_t'(insn);
    match   = (fields.major == MAJOR_OP) && (fields.xo_fix == XO_SUB);
    accept  = insn_valid && match;
    illegal = insn_valid && !match;
    // zero immediate stands for the full length
    if (fields.imm == '0) imm_val = VL_W'(MAXVL);
    else                  imm_val = {1'b0, fields.imm};
  end

endmodule

// File: rtl/svl_clamp.sv
module svl_clamp
  import svl_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  svl_word_t       fields,
  input  logic [VL_W-1:0] imm_val,
  input  logic [VL_W-1:0] cur_vl,
  input  logic [VL_W-1:0] cur_mvl,
  input  logic [XLEN-1:0] rs_data,
  output logic [VL_W-1:0] mvl_nxt,
  output logic [VL_W-1:0] vl_nxt
);

  logic            rs_over;
  logic [VL_W-1:0] rs_low;
  logic [VL_W-1:0] base;
  logic [VL_W-1:0] capped;

  generate
    if (XLEN > VL_W) begin : g_wide
      assign rs_over = |rs_data[XLEN-1:VL_W];
      assign rs_low  = rs_data[VL_W-1:0];
    end else begin : g_narrow
      assign rs_over = 1'b0;
      assign rs_low  = VL_W'(rs_data);
    end
  endgenerate

  always_comb begin
    mvl_nxt = fields.set_mvl ? imm_val : cur_mvl;
    base    = fields.set_vl  ? imm_val : cur_vl;
    capped  = umin(base, mvl_nxt);
    if ((fields.ra != '0) && !rs_over) vl_nxt = umin(capped, rs_low);
    else                               vl_nxt = capped;
  end

endmodule

// File: rtl/svl_state.sv
module svl_state
  import svl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic            rc,
  input  logic [VL_W-1:0] vl_nxt,
  input  logic [VL_W-1:0] mvl_nxt,
  output logic [VL_W-1:0] vl,
  output logic [VL_W-1:0] mvl,
  output logic [3:0]      cr0
);

  logic [VL_W-1:0] vl_q, vl_d;
  logic [VL_W-1:0] mvl_q, mvl_d;
  logic [3:0]      cr0_q, cr0_d;
  logic            cr_en;

  always_comb begin
    cr_en = upd && rc;
    vl_d  = upd   ? vl_nxt  : vl_q;
    mvl_d = upd   ? mvl_nxt : mvl_q;
    cr0_d = cr_en ? {1'b0, (vl_nxt != '0), (vl_nxt == '0), 1'b0} : cr0_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q  <= '0;
      mvl_q <= '0;
      cr0_q <= '0;
    end else begin
      vl_q  <= vl_d;
      mvl_q <= mvl_d;
      cr0_q <= cr0_d;
    end
  end

  assign vl  = vl_q;
  assign mvl = mvl_q;
  assign cr0 = cr0_q;

endmodule

// File: rtl/svl_unit.sv
module svl_unit
  import svl_pkg::*;
#(
  parameter int         XLEN     = 64,
  parameter logic [5:0] MAJOR_OP = 6'd22,
  parameter logic [4:0] XO_SUB   = 5'd27
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               insn_valid,
  input  logic [31:0]        insn,
  output logic [RADDR_W-1:0] rs_addr,
  input  logic [XLEN-1:0]    rs_data,
  output logic               rd_we,
  output logic [RADDR_W-1:0] rd_addr,
  output logic [XLEN-1:0]    rd_data,
  output logic [VL_W-1:0]    vl,
  output logic [VL_W-1:0]    mvl,
  output logic [3:0]         cr0,
  output logic               illegal
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  svl_word_t       fields;
  logic [VL_W-1:0] imm_val;
  logic            accept;
  logic [VL_W-1:0] vl_nxt, mvl_nxt;

  svl_decode #(.MAJOR_OP(MAJOR_OP), .XO_SUB(XO_SUB)) u_dec (
    .insn_valid (insn_valid),
    .insn       (insn),
    .fields     (fields),
    .imm_val    (imm_val),
    .accept     (accept),
    .illegal    (illegal)
  );

  svl_clamp #(.XLEN(XLEN)) u_clamp (
    .fields  (fields),
    .imm_val (imm_val),
    .cur_vl  (vl),
    .cur_mvl (mvl),
    .rs_data (rs_data),
    .mvl_nxt (mvl_nxt),
    .vl_nxt  (vl_nxt)
  );

  svl_state u_state (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .upd     (accept),
    .rc      (fields.rc),
    .vl_nxt  (vl_nxt),
    .mvl_nxt (mvl_nxt),
    .vl      (vl),
    .mvl     (mvl),
    .cr0     (cr0)
  );

  always_comb begin
    rs_addr = fields.ra;
    rd_we   = accept && (fields.rt != '0);
    rd_addr = fields.rt;
    rd_data = {{(XLEN-VL_W){1'b0}}, vl_nxt};
  end

endmodule

// File: rtl/svl_unit_chk.sv
module svl_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_valid,
  input logic [31:0]     insn,
  input logic            rd_we,
  input logic [4:0]      rd_addr,
  input logic [XLEN-1:0] rd_data,
  input logic [6:0]      vl,
  input logic [6:0]      mvl,
  input logic [3:0]      cr0,
  input logic            illegal
);

  // R10
  vl_within_mvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vl <= mvl) && (mvl <= 7'd64));

  // R6
  no_write_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (rd_addr != 5'd0));

  // R1
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> ($stable(vl) && $stable(mvl) && $stable(cr0)));

  // R1
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !rd_we);

  // R6
  written_vl_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |=> (vl == $past(rd_data[6:0])));

  // R8
  cr0_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !illegal && insn[0]) |=> (cr0 == {1'b0, (vl != 7'd0), (vl == 7'd0), 1'b0}));

  // R8
  cr0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(insn_valid && insn[0]) |=> $stable(cr0));

endmodule

bind svl_unit svl_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .insn_valid (insn_valid),
  .insn       (insn),
  .rd_we      (rd_we),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .vl         (vl),
  .mvl        (mvl),
  .cr0        (cr0),
  .illegal    (illegal)
);

// File: tb/svl_unit_tb.sv
`timescale 1ns/1ps
module svl_unit_tb_top;

  localparam logic [5:0] MAJ = 6'd22;
  localparam logic [4:0] XOS = 5'd27;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid;
  logic [31:0] insn;
  logic [4:0]  rs_addr;
  logic [63:0] rs_data;
  logic        rd_we;
  logic [4:0]  rd_addr;
  logic [63:0] rd_data;
  logic [6:0]  vl, mvl;
  logic [3:0]  cr0;
  logic        illegal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  int          m_vl, m_mvl;
  logic [3:0]  m_cr0;

  always #5 clk = ~clk;

  svl_unit #(.XLEN(64), .MAJOR_OP(MAJ), .XO_SUB(XOS)) dut_i (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
    .rs_addr(rs_addr), .rs_data(rs_data), .rd_we(rd_we), .rd_addr(rd_addr),
    .rd_data(rd_data), .vl(vl), .mvl(mvl), .cr0(cr0), .illegal(illegal)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] maj, input logic [4:0] rt,
                                     input logic [5:0] imm, input logic smvl,
                                     input logic svl, input logic [1:0] rsvd,
                                     input logic [4:0] ra, input logic [4:0] xo,
                                     input logic rc);
    return {maj, rt, imm, smvl, svl, rsvd, ra, xo, rc};
  endfunction

  // Apply one word just after a falling edge, check the write port, then the state.
  task automatic apply(input logic [31:0] w, input logic [63:0] src, input string tag);
    logic        legal;
    int          immv, mvl_n, base, v;
    logic [4:0]  rt, ra;
    legal = (w[31:26] == MAJ) && (w[5:1] == XOS);
    rt    = w[25:21];
    ra    = w[10:6];
    immv  = (w[20:15] == 6'd0) ? 64 : int'(w[20:15]);
    mvl_n = w[14] ? immv : m_mvl;
    base  = w[13] ? immv : m_vl;
    v     = (base < mvl_n) ? base : mvl_n;
    if (ra != 5'd0 && src < 64'(v)) v = int'(src);
    insn = w; rs_data = src; insn_valid = 1'b1;
    #1;
    check({tag, " R1 illegal"}, illegal, !legal);
    check({tag, " R2 rs_addr"}, rs_addr, ra);
    check({tag, " R6 rd_we"}, rd_we, legal && rt != 5'd0);
    if (legal && rt != 5'd0) begin
      check({tag, " R2 rd_addr"}, rd_addr, rt);
      check({tag, " R5 R6 rd_data"}, rd_data, 64'(v));
      if (ra != 5'd0 && src == 64'd0) check({tag, " R11 zero source"}, rd_data, 64'd0);
    end
    if (legal) begin
      m_mvl = mvl_n;
      m_vl  = v;
      if (w[0]) m_cr0 = {1'b0, v != 0, v == 0, 1'b0};
    end
    @(posedge clk); #1;
    insn_valid = 1'b0;
    check({tag, " R4 mvl"}, mvl, 64'(m_mvl));
    check({tag, " R5 vl"}, vl, 64'(m_vl));
    check({tag, " R8 cr0"}, cr0, m_cr0);
    check({tag, " R10 vl<=mvl"}, vl <= mvl, 1'b1);
    @(negedge clk);
  endtask

  function automatic logic [63:0] src_of(input int k);
    case (k % 7)
      0: return 64'd0;
      1: return 64'd1;
      2: return 64'(k % 70);
      3: return 64'd63;
      4: return 64'd64;
      5: return 64'd65;
      default: return 64'hFFFF_0000_0000_0003;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    rst_n = 1'b0; insn_valid = 1'b0; insn = '0; rs_data = '0;
    m_vl = 0; m_mvl = 0; m_cr0 = 4'd0;
    repeat (3) @(negedge clk);
    check("R9 reset vl", vl, 0);
    check("R9 reset mvl", mvl, 0);
    check("R9 reset cr0", cr0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 post-release vl", vl, 0);

    // R7: RA=0 with a nonzero source, no set flags: VL stays 0 regardless of rs_data
    apply(mk(MAJ, 5'd3, 6'd9, 1'b0, 1'b0, 2'd0, 5'd0, XOS, 1'b1), 64'd40, "R7 ra0");
    // R3: immediate 0 gives 64
    apply(mk(MAJ, 5'd4, 6'd0, 1'b1, 1'b1, 2'd0, 5'd0, XOS, 1'b1), 64'd0, "R3 imm0");
    check("R3 mvl is 64", mvl, 64);
    // R7: RA=0 ignores a small source when VL is reloaded
    apply(mk(MAJ, 5'd5, 6'd20, 1'b0, 1'b1, 2'd3, 5'd0, XOS, 1'b0), 64'd2, "R7 ra0 load");
    check("R7 vl not limited by rs", vl, 20);

    k = 0;
    for (int imm = 0; imm < 64; imm++)
      for (int fl = 0; fl < 4; fl++)
        for (int ram = 0; ram < 2; ram++)
          for (int rc = 0; rc < 2; rc++) begin
            logic [4:0] rt, ra;
            rt = (k % 3 == 0) ? 5'd0 : 5'((k % 31) + 1);
            ra = (ram == 1) ? 5'((k % 31) + 1) : 5'd0;
            apply(mk(MAJ, rt, 6'(imm), fl[1], fl[0], 2'(k % 4), ra, XOS, rc[0]),
                  src_of(k), "sweep R2 R3 R4 R5");
            k++;
          end

    // R11: zero source yields VL 0 with eq raised
    apply(mk(MAJ, 5'd7, 6'd30, 1'b1, 1'b1, 2'd0, 5'd9, XOS, 1'b1), 64'd0, "R11");
    check("R11 cr0 eq", cr0, 4'b0010);

    for (int mj = 0; mj < 64; mj++)
      apply(mk(6'(mj), 5'd6, 6'(mj + 1), 1'b1, 1'b1, 2'd0, 5'd0, XOS, 1'b1),
            64'd0, "major sweep R1");
    for (int xo = 0; xo < 32; xo++)
      apply(mk(MAJ, 5'd8, 6'(xo + 2), 1'b1, 1'b1, 2'd0, 5'd0, 5'(xo), xo[0]),
            64'd0, "xo sweep R1");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule